// File: doc/BRIEF.md
# Vertical Chroma Halving Filter for 4:2:2 Video

This block sits in a camera pipeline after the colour-space stage and turns a 4:2:2 YCbCr line stream into 4:2:0. Each incoming pixel carries a luma sample and one chroma sample, with Cb and Cr alternating along the line. Lines are grouped in pairs, counted from the frame start. The block stores the chroma of the first line of a pair in a line buffer. On the second line it blends the stored chroma with the new chroma, column by column, into one chroma line that sits centred between the two source lines. Luma passes through on every line.

Two blends are available. The progressive blend weights both lines equally. The interlaced blend weights them 3:1 or 1:3, depending on the field parity flag that comes with the line. With the enable low, the stream passes through unchanged as 4:2:2. Every output is registered once, so luma and chroma leave together one cycle after the pixel enters.

Top module: `chroma_vdown`

## Requirements
- R1: While reset is held and after its release with no input, `out_valid` and `out_c_valid` are 0, and `out_y` and `out_c` are 0.
- R2: Each pixel accepted with `in_valid` = 1 appears one clock later with `out_valid` = 1 and `out_y` equal to its `in_y`, whatever the mode. A cycle with `in_valid` = 0 gives `out_valid` = 0 one clock later.
- R3: With `en` = 0, every output pixel has `out_c_valid` = 1 and `out_c` equal to the input chroma one clock earlier.
- R4: With `en` = 1, lines alternate between first and second of a pair. On the first line, every pixel has `out_c_valid` = 0 and `out_c` = 0. On the second line, every pixel has `out_c_valid` = 1. A third line starts a new pair.
- R5: With `field_mode` = 0, the second-line chroma is (a + b + 1) >> 1. Here a is the first-line chroma in the same column and b is the current chroma.
- R6: With `field_mode` = 1 and `in_field` = 0 (top field) on the second line, the chroma is (3a + b + 2) >> 2.
- R7: With `field_mode` = 1 and `in_field` = 1 (bottom field) on the second line, the chroma is (a + 3b + 2) >> 2.
- R8: A line that starts with `in_sof` = 1 is always the first line of a pair, even if the previous line was also a first line.
- R9: The column index restarts at 0 on each pixel with `in_sol` = 1. Chroma is paired by column position, for up to MAX_W columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | 1: subsample to 4:2:0; 0: pass 4:2:2 through |
| field_mode | input | 1 | 0: equal-weight blend; 1: field-weighted blend |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame (set together with in_sol) |
| in_field | input | 1 | Field parity: 0 top, 1 bottom |
| in_y | input | DW | Luma sample |
| in_c | input | DW | Chroma sample (Cb or Cr) |
| out_valid | output | 1 | Output pixel qualifier |
| out_y | output | DW | Luma sample, one cycle delayed |
| out_c | output | DW | Chroma sample |
| out_c_valid | output | 1 | Chroma on this pixel is meaningful |

## Verification
The bench walks a table of first/second line chroma pairs through all three blends. The values are chosen so that rounding decides the result: odd sums, a total of one or two, full scale, and zero. A design that rounds down, or that swaps the top and bottom weights, reports a value one step off or with the weights mirrored. Directed tests send a frame start on what would be a second line, lines whose chroma changes per column, and a disabled stream. A design that does not reset the pairing, shifts the column index, or still filters when disabled either emits chroma on the wrong line or emits the wrong blend.

// File: rtl/chroma_vdown.sv
module chroma_vdown #(
  parameter int DW    = 8,
  parameter int MAX_W = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          field_mode,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_sof,
  input  logic          in_field,
  input  logic [DW-1:0] in_y,
  input  logic [DW-1:0] in_c,
  output logic          out_valid,
  output logic [DW-1:0] out_y,
  output logic [DW-1:0] out_c,
  output logic          out_c_valid
);
  localparam int AW = $clog2(MAX_W);
  localparam logic [DW+1:0] ONE = 1;
  localparam logic [DW+1:0] TWO = 2;

  logic [DW-1:0] lbuf [MAX_W];
  logic [AW-1:0] col_q;
  logic          par_q;

  wire [AW-1:0] col  = in_sol ? '0 : col_q;
  wire          par  = in_sof ? 1'b0 : (in_sol ? ~par_q : par_q);
  wire [DW-1:0] up_c = lbuf[col];

  wire [DW+1:0] ea  = {2'b00, up_c};
  wire [DW+1:0] eb  = {2'b00, in_c};
  wire [DW+1:0] avg = (ea + eb + ONE) >> 1;
  wire [DW+1:0] top = ((ea << 1) + ea + eb + TWO) >> 2;
  wire [DW+1:0] bot = ((eb << 1) + eb + ea + TWO) >> 2;

  logic [DW-1:0] filt;
  always_comb begin
    if (!field_mode)   filt = avg[DW-1:0];
    else if (in_field) filt = bot[DW-1:0];
    else               filt = top[DW-1:0];
  end

  always_ff @(posedge clk)
    if (in_valid && !par) lbuf[col] <= in_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q       <= '0;
      par_q       <= 1'b0;
      out_valid   <= 1'b0;
      out_c_valid <= 1'b0;
      out_y       <= '0;
      out_c       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        col_q       <= col + 1'b1;
        par_q       <= par;
        out_y       <= in_y;
        out_c_valid <= !en || par;
        out_c       <= !en ? in_c : (par ? filt : '0);
      end else begin
        out_c_valid <= 1'b0;
      end
    end
  end
endmodule

module chroma_vdown_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          in_valid,
  input logic          in_sof,
  input logic [DW-1:0] in_y,
  input logic [DW-1:0] in_c,
  input logic          out_valid,
  input logic [DW-1:0] out_y,
  input logic [DW-1:0] out_c,
  input logic          out_c_valid
);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_luma_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_y == $past(in_y)));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !en) |=> (out_c_valid && out_c == $past(in_c)));
  assert_cv_qualified_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_c_valid |-> out_valid);
  assert_first_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_c_valid) |-> out_c == '0);
  assert_sof_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && en) |=> !out_c_valid);
endmodule

bind chroma_vdown chroma_vdown_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_sof(in_sof),
  .in_y(in_y), .in_c(in_c), .out_valid(out_valid), .out_y(out_y),
  .out_c(out_c), .out_c_valid(out_c_valid)
);

// File: tb/sim_chroma_vdown.sv
`timescale 1ns/1ps
module sim_chroma_vdown;
  logic clk = 0, rst_n = 0, en = 0, field_mode = 0;
  logic in_valid = 0, in_sol = 0, in_sof = 0, in_field = 0;
  logic [7:0] in_y = 0, in_c = 0;
  logic out_valid, out_c_valid;
  logic [7:0] out_y, out_c;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  chroma_vdown u0 (.clk, .rst_n, .en, .field_mode, .in_valid, .in_sol, .in_sof,
    .in_field, .in_y, .in_c, .out_valid, .out_y, .out_c, .out_c_valid);

  // {field_mode, field, a, b, expected}
  localparam logic [25:0] VEC [13] = '{
    {1'b0,1'b0,8'd10, 8'd20, 8'd15},
    {1'b0,1'b0,8'd10, 8'd11, 8'd11},
    {1'b0,1'b0,8'd255,8'd0,  8'd128},
    {1'b0,1'b0,8'd0,  8'd0,  8'd0},
    {1'b0,1'b1,8'd255,8'd255,8'd255},
    {1'b1,1'b0,8'd100,8'd0,  8'd75},
    {1'b1,1'b0,8'd0,  8'd100,8'd25},
    {1'b1,1'b0,8'd255,8'd255,8'd255},
    {1'b1,1'b0,8'd1,  8'd0,  8'd1},
    {1'b1,1'b0,8'd2,  8'd1,  8'd2},
    {1'b1,1'b1,8'd100,8'd0,  8'd25},
    {1'b1,1'b1,8'd0,  8'd100,8'd75},
    {1'b1,1'b1,8'd0,  8'd1,  8'd1}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_line(input logic sof, input logic [7:0] base, input logic [7:0] step,
                           input logic ecv, input logic [7:0] ebase, input logic [7:0] estep,
                           input string req);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1; in_sol = (i == 0); in_sof = sof && (i == 0);
      in_y = 8'h40 + 8'(i); in_c = base + 8'(i) * step;
      @(posedge clk); #2;
      check(out_valid && out_y == 8'h40 + 8'(i), "R2", out_y, 8'h40 + i);
      check(out_c_valid == ecv, {req, " cv"}, out_c_valid, ecv);
      check(out_c == ebase + 8'(i) * estep, req, out_c, ebase + 8'(i) * estep);
    end
    in_valid = 0; in_sol = 0; in_sof = 0;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && !out_c_valid && out_y == 0 && out_c == 0, "R1 in reset", out_valid, 0);
    rst_n = 1;
    @(posedge clk); #2;
    check(!out_valid && !out_c_valid, "R1 after release", out_c_valid, 0);

    en = 1;
    foreach (VEC[k]) begin
      field_mode = VEC[k][25]; in_field = VEC[k][24];
      send_line(1'b1, VEC[k][23:16], 8'd0, 1'b0, 8'd0, 8'd0, "R4 first");
      send_line(1'b0, VEC[k][15:8], 8'd0, 1'b1, VEC[k][7:0], 8'd0,
                VEC[k][25] ? (VEC[k][24] ? "R7" : "R6") : "R5");
    end

    // R4: third line opens a new pair
    field_mode = 0; in_field = 0;
    send_line(1'b1, 8'd8, 8'd0, 1'b0, 8'd0, 8'd0, "R4");
    send_line(1'b0, 8'd12, 8'd0, 1'b1, 8'd10, 8'd0, "R4");
    send_line(1'b0, 8'd50, 8'd0, 1'b0, 8'd0, 8'd0, "R4 third");
    send_line(1'b0, 8'd60, 8'd0, 1'b1, 8'd55, 8'd0, "R4 fourth");

    // R8: frame start on what would be a second line
    send_line(1'b1, 8'd40, 8'd0, 1'b0, 8'd0, 8'd0, "R8");
    send_line(1'b1, 8'd80, 8'd0, 1'b0, 8'd0, 8'd0, "R8 sof line");
    send_line(1'b0, 8'd0, 8'd0, 1'b1, 8'd40, 8'd0, "R8 blend");

    // R9: per-column pairing
    send_line(1'b1, 8'd0, 8'd10, 1'b0, 8'd0, 8'd0, "R9");
    send_line(1'b0, 8'd100, 8'd0, 1'b1, 8'd50, 8'd5, "R9");

    // R2: idle gap
    @(posedge clk); #2;
    check(!out_valid, "R2 idle", out_valid, 0);

    // R3: disabled pass-through, even across a new frame
    en = 0;
    send_line(1'b1, 8'd77, 8'd3, 1'b1, 8'd77, 8'd3, "R3");
    send_line(1'b0, 8'd200, 8'd1, 1'b1, 8'd200, 8'd1, "R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule